// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block expands one decoded vector integer or floating-point load into a stream of per-element memory read requests. A one-cycle `start` pulse captures the instruction fields, the vector length, the per-register vectorised flags, the predicate mask and the zeroing flag. The block then walks the element index upward from zero. For each element whose predicate bit is set, it issues one request that carries a 64-bit byte address, a size code and a destination register number. Requests use a valid/ready handshake.

Two mode bits choose how the per-element offset is formed. With the indexed bit set, the offset is the value of a second source register. With both bits clear, the offset is the element index scaled by the element size. With only the scaled bit set, that product is multiplied again by the second source register. Register operands are read through two combinational register-file read ports. Any operand flagged as vectorised steps one register number per element. A scalar destination ends the loop at the first issued element.

Top module: `vld_addr_seq`

## Requirements
- R1: `req_size` equals the 2-bit element size code `op_wsel` captured at start; the element size in bytes is 1 << code (0: 1 byte, 1: 2, 2: 4, 3: 8).
- R2: With `op_indexed`=0 and `op_scaled`=0, the address of element i is base(i) + i·size + sext(imm).
- R3: With `op_indexed`=0 and `op_scaled`=1, the address of element i is base(i) + i·size·src2(i) + sext(imm).
- R4: With `op_indexed`=1, the address of element i is base(i) + src2(i) + sext(imm), whatever the value of `op_scaled`.
- R5: A register number r whose bit r in `vec_mask` is set resolves to (r+i) mod 32 for element i; otherwise it resolves to r. This applies to the base (`op_rs1`), the second source (`op_rs2`) and the destination (`op_rd`). `req_dst` carries the resolved destination.
- R6: Element i produces a request only when bit i of `pred_mask` is set. Requests leave in ascending element order.
- R7: When the destination is not vectorised, the sequence ends after the first request is accepted.
- R8: When the destination is not vectorised and `pred_zeroing` is set, `exc` and `done` are raised together for one cycle and no request is made.
- R9: `done` pulses for exactly one cycle when the loop ends. A vector length of 0 gives `done` with no request. A vector length above 16 is treated as 16.
- R10: A pending request keeps `req_valid`, `req_addr`, `req_size` and `req_dst` unchanged until `req_ready` is seen high.
- R11: Address arithmetic wraps modulo 2^64, and the 12-bit immediate is sign-extended.
- R12: `start` and every instruction input are ignored while a sequence is in progress. The running sequence uses the values captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the instruction and begin a sequence |
| op_indexed | input | 1 | Mode bit: offset comes from a register |
| op_scaled | input | 1 | Mode bit: stride multiplied by a register (when not indexed) |
| op_rs2 | input | 5 | Second source register number |
| op_rs1 | input | 5 | Base register number |
| op_wsel | input | 2 | Element size code |
| op_rd | input | 5 | Destination register number |
| op_imm | input | 12 | Signed immediate |
| vl | input | 5 | Vector length |
| vec_mask | input | 32 | Vectorised flag per register |
| pred_mask | input | 16 | Predicate bit per element |
| pred_zeroing | input | 1 | Zeroing enabled on the predicate |
| rf_a_idx | output | 5 | Register-file read index for the base |
| rf_a_data | input | 64 | Read data for `rf_a_idx` |
| rf_b_idx | output | 5 | Register-file read index for the second source |
| rf_b_data | input | 64 | Read data for `rf_b_idx` |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 64 | Byte address |
| req_size | output | 2 | Element size code |
| req_dst | output | 5 | Destination register number |
| done | output | 1 | One-cycle end-of-sequence pulse |
| exc | output | 1 | One-cycle exception pulse (scalar destination with zeroing) |

## Verification
A corrupted element index or predicate copy shows up at the ports on the next accepted request. The address would be off by a multiple of the stride, or a request would appear for a masked lane, or a lane would be missing. A wrong loop-end decision shows up as a request count that disagrees with `done`, one cycle after the last transfer. A wrong resolved register shows up in `req_dst` or in the address within the same request. The bench holds `req_ready` low at random, so a pending request that is not held stable is caught on the following cycle.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SEND = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    AM_ELEM  = 2'd0,
    AM_CONST = 2'd1,
    AM_INDEX = 2'd2
  } addr_mode_t;

  function automatic addr_mode_t decode_mode(input logic indexed, input logic scaled);
    if (indexed)     return AM_INDEX;
    else if (scaled) return AM_CONST;
    else             return AM_ELEM;
  endfunction
endpackage

// File: rtl/vls_reg_resolve.sv
module vls_reg_resolve #(
  parameter int RIW  = 5,
  parameter int IDXW = 5
) (
  input  logic [RIW-1:0]  reg_base,
  input  logic [IDXW-1:0] elem_idx,
  input  logic            is_vec,
  output logic [RIW-1:0]  reg_eff
);
  // register number wraps modulo the register count
  always_comb begin
    if (is_vec) reg_eff = reg_base + RIW'(elem_idx);
    else        reg_eff = reg_base;
  end
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
  import vls_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IDXW = 5,
  parameter int IMMW = 12
) (
  input  addr_mode_t       mode,
  input  logic [1:0]       size_code,
  input  logic [IDXW-1:0]  elem_idx,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  src2_val,
  input  logic [IMMW-1:0]  imm,
  output logic [XLEN-1:0]  addr
);
  localparam int EXTW = XLEN - IMMW;

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] idx_x;
  logic [XLEN-1:0] offset;

  assign imm_sx = {{EXTW{imm[IMMW-1]}}, imm};
  assign idx_x  = XLEN'(elem_idx);

  always_comb begin
    unique case (mode)
      AM_INDEX: offset = src2_val;
      AM_CONST: offset = (idx_x * src2_val) << size_code;
      default:  offset = idx_x << size_code;
    endcase
    addr = base_val + offset + imm_sx;
  end
endmodule

// File: rtl/vld_addr_seq.sv
module vld_addr_seq
  import vls_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int RIW   = 5,
  parameter int MAXVL = 16,
  parameter int IMMW  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          op_indexed,
  input  logic                          op_scaled,
  input  logic [RIW-1:0]                op_rs2,
  input  logic [RIW-1:0]                op_rs1,
  input  logic [1:0]                    op_wsel,
  input  logic [RIW-1:0]                op_rd,
  input  logic [IMMW-1:0]               op_imm,
  input  logic [$clog2(MAXVL+1)-1:0]    vl,
  input  logic [(1<<RIW)-1:0]           vec_mask,
  input  logic [MAXVL-1:0]              pred_mask,
  input  logic                          pred_zeroing,
  output logic [RIW-1:0]                rf_a_idx,
  input  logic [XLEN-1:0]               rf_a_data,
  output logic [RIW-1:0]                rf_b_idx,
  input  logic [XLEN-1:0]               rf_b_data,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [XLEN-1:0]               req_addr,
  output logic [1:0]                    req_size,
  output logic [RIW-1:0]                req_dst,
  output logic                          done,
  output logic                          exc
);
  localparam int NREG = 1 << RIW;
  localparam int IDXW = $clog2(MAXVL + 1);

  seq_state_t        state;
  addr_mode_t        mode_q;
  logic [RIW-1:0]    rs1_q, rs2_q, rd_q;
  logic [1:0]        wsel_q;
  logic [IMMW-1:0]   imm_q;
  logic [IDXW-1:0]   vl_q;
  logic [NREG-1:0]   vmask_q;
  logic [MAXVL-1:0]  pmask_q;
  logic [IDXW-1:0]   idx;

  logic              pred_bit;
  logic              rd_vec;
  logic [RIW-1:0]    dst_c;
  logic [XLEN-1:0]   addr_c;
  logic [IDXW-1:0]   vl_clamped;

  assign vl_clamped = (vl > IDXW'(MAXVL)) ? IDXW'(MAXVL) : vl;
  assign rd_vec     = vmask_q[rd_q];

  always_comb begin
    pred_bit = 1'b0;
    for (int k = 0; k < MAXVL; k++)
      if (idx == IDXW'(k)) pred_bit = pmask_q[k];
  end

  vls_reg_resolve #(.RIW(RIW), .IDXW(IDXW)) u_res_base (
    .reg_base(rs1_q), .elem_idx(idx), .is_vec(vmask_q[rs1_q]), .reg_eff(rf_a_idx));
  vls_reg_resolve #(.RIW(RIW), .IDXW(IDXW)) u_res_src2 (
    .reg_base(rs2_q), .elem_idx(idx), .is_vec(vmask_q[rs2_q]), .reg_eff(rf_b_idx));
  vls_reg_resolve #(.RIW(RIW), .IDXW(IDXW)) u_res_dst (
    .reg_base(rd_q), .elem_idx(idx), .is_vec(rd_vec), .reg_eff(dst_c));

  vls_addr_gen #(.XLEN(XLEN), .IDXW(IDXW), .IMMW(IMMW)) u_agen (
    .mode(mode_q), .size_code(wsel_q), .elem_idx(idx), .base_val(rf_a_data),
    .src2_val(rf_b_data), .imm(imm_q), .addr(addr_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= AM_ELEM;
      rs1_q     <= '0;
      rs2_q     <= '0;
      rd_q      <= '0;
      wsel_q    <= '0;
      imm_q     <= '0;
      vl_q      <= '0;
      vmask_q   <= '0;
      pmask_q   <= '0;
      idx       <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_size  <= '0;
      req_dst   <= '0;
      done      <= 1'b0;
      exc       <= 1'b0;
    end else begin
      done <= 1'b0;
      exc  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q  <= decode_mode(op_indexed, op_scaled);
            rs1_q   <= op_rs1;
            rs2_q   <= op_rs2;
            rd_q    <= op_rd;
            wsel_q  <= op_wsel;
            imm_q   <= op_imm;
            vl_q    <= vl_clamped;
            vmask_q <= vec_mask;
            pmask_q <= pred_mask;
            idx     <= '0;
            if (!vec_mask[op_rd] && pred_zeroing) begin
              exc  <= 1'b1;
              done <= 1'b1;
            end else begin
              state <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (idx >= vl_q) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (!pred_bit) begin
            idx <= idx + 1'b1;
          end else begin
            req_valid <= 1'b1;
            req_addr  <= addr_c;
            req_size  <= wsel_q;
            req_dst   <= dst_c;
            state     <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            if (!rd_vec) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_SCAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: pending request stays put until accepted
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_size) && $stable(req_dst)));

  // R9: end pulse lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: requests only inside the vector length
  p_idx_bound_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (idx < vl_q));

  // R6: a pending request belongs to an active lane
  p_pred_gate_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> pred_bit);

  // R8: exception comes with done and without a request
  p_exc_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    exc |-> (done && !req_valid));

  // R7: scalar destination stops after the first accepted transfer
  p_scalar_end_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !rd_vec) |=> (done && !req_valid));
endmodule

// File: tb/sim_vld_addr_seq.sv
`timescale 1ns/1ps
module sim_vld_addr_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        op_indexed, op_scaled;
  logic [4:0]  op_rs2, op_rs1, op_rd;
  logic [1:0]  op_wsel;
  logic [11:0] op_imm;
  logic [4:0]  vl;
  logic [31:0] vec_mask;
  logic [15:0] pred_mask;
  logic        pred_zeroing;
  logic [4:0]  rf_a_idx, rf_b_idx;
  logic [63:0] rf_a_data, rf_b_data;
  logic        req_valid, req_ready;
  logic [63:0] req_addr;
  logic [1:0]  req_size;
  logic [4:0]  req_dst;
  logic        done, exc;

  logic [63:0] rf [32];
  assign rf_a_data = rf[rf_a_idx];
  assign rf_b_data = rf[rf_b_idx];

  always #2 clk = ~clk;

  vld_addr_seq u0 (
    .clk(clk), .rst(rst), .start(start), .op_indexed(op_indexed), .op_scaled(op_scaled),
    .op_rs2(op_rs2), .op_rs1(op_rs1), .op_wsel(op_wsel), .op_rd(op_rd), .op_imm(op_imm),
    .vl(vl), .vec_mask(vec_mask), .pred_mask(pred_mask), .pred_zeroing(pred_zeroing),
    .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_dst(req_dst), .done(done), .exc(exc));

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [63:0] e_addr [16];
  logic [4:0]  e_dst [16];
  int          e_n;
  bit          e_exc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] rsv(input logic [4:0] r, input int i, input logic [31:0] vm);
    return vm[r] ? 5'(r + 5'(i)) : r;
  endfunction

  task automatic build_exp(input bit b31, input bit b30, input logic [4:0] rs2,
                           input logic [4:0] rs1, input logic [1:0] w, input logic [4:0] rd,
                           input logic [11:0] imm, input int n, input logic [31:0] vm,
                           input logic [15:0] pm, input bit pz);
    logic [63:0] s1, s2, off, esz, ix;
    e_n = 0;
    e_exc = 0;
    if (!vm[rd] && pz) begin
      e_exc = 1;
      return;
    end
    esz = 64'd1 << w;
    for (int i = 0; i < n && i < 16; i++) begin
      if (pm[i]) begin
        s1 = rf[rsv(rs1, i, vm)];
        s2 = rf[rsv(rs2, i, vm)];
        ix = 64'(i);
        if (b31)      off = s2;
        else if (b30) off = ix * esz * s2;
        else          off = ix * esz;
        e_addr[e_n] = s1 + off + {{52{imm[11]}}, imm};
        e_dst[e_n]  = rsv(rd, i, vm);
        e_n++;
        if (!vm[rd]) break;
      end
    end
  endtask

  task automatic run_op(input string tag, input bit b31, input bit b30, input logic [4:0] rs2,
                        input logic [4:0] rs1, input logic [1:0] w, input logic [4:0] rd,
                        input logic [11:0] imm, input logic [4:0] n, input logic [31:0] vm,
                        input logic [15:0] pm, input bit pz, input bit mid);
    int got, cyc;
    bit seen, stall, rdy;
    logic [63:0] held;
    build_exp(b31, b30, rs2, rs1, w, rd, imm, int'(n), vm, pm, pz);
    @(negedge clk);
    op_indexed = b31; op_scaled = b30; op_rs2 = rs2; op_rs1 = rs1; op_wsel = w;
    op_rd = rd; op_imm = imm; vl = n; vec_mask = vm; pred_mask = pm; pred_zeroing = pz;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble inputs: captured values must rule (R12)
    op_indexed = 1'($urandom); op_scaled = 1'($urandom); op_rs2 = 5'($urandom);
    op_rs1 = 5'($urandom); op_wsel = 2'($urandom); op_rd = 5'($urandom);
    op_imm = 12'($urandom); vl = 5'($urandom); vec_mask = $urandom;
    pred_mask = 16'($urandom); pred_zeroing = 1'($urandom);
    got = 0; seen = 0; stall = 0; held = '0;
    for (cyc = 0; cyc < 400 && !seen; cyc++) begin
      start = (mid && cyc == 3);
      if (done) begin
        seen = 1;
        chk(exc == e_exc, tag, "R8 exc at done", 64'(exc), 64'(e_exc));
        chk(got == e_n, tag, "R6 R9 request count", 64'(got), 64'(e_n));
        chk(!req_valid, tag, "R9 no request with done", 64'(req_valid), 64'd0);
      end else begin
        if (exc) chk(0, tag, "R8 exc without done", 64'(exc), 64'd0);
        if (stall) begin
          chk(req_valid && req_addr == held, tag, "R10 held request", req_addr, held);
        end
        if (req_valid) begin
          rdy = ($urandom % 4) != 0;
          req_ready = rdy;
          if (rdy) begin
            if (got < e_n) begin
              chk(req_addr == e_addr[got], tag, "R2 R3 R4 R11 address", req_addr, e_addr[got]);
              chk(req_dst == e_dst[got], tag, "R5 destination", 64'(req_dst), 64'(e_dst[got]));
              chk(req_size == w, tag, "R1 size", 64'(req_size), 64'(w));
            end else begin
              chk(0, tag, "R6 R7 extra request", 64'(got + 1), 64'(e_n));
            end
            got++;
          end
          stall = !rdy;
          held = req_addr;
        end else begin
          req_ready = 1'($urandom);
          stall = 0;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    req_ready = 1'b0;
    if (!seen) chk(0, tag, "R9 done never seen", 64'd0, 64'd1);
    @(negedge clk);
    chk(!done, tag, "R9 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; start = 0; req_ready = 0;
    op_indexed = 0; op_scaled = 0; op_rs2 = 0; op_rs1 = 0; op_wsel = 0; op_rd = 0;
    op_imm = 0; vl = 0; vec_mask = 0; pred_mask = 0; pred_zeroing = 0;
    for (int r = 0; r < 32; r++) rf[r] = 64'h1000 * r + 64'h10;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!req_valid && !done && !exc, "reset", "R9 idle outputs", {61'd0, req_valid, done, exc}, 64'd0);

    rf[3] = 64'h8000_0000; rf[7] = 64'd3;
    run_op("R2 elem stride", 0, 0, 5'd7, 5'd3, 2'd3, 5'd10, 12'h010, 5'd5, 32'h0000_0400, 16'hFFFF, 0, 0);
    run_op("R3 const stride scalar", 0, 1, 5'd7, 5'd3, 2'd1, 5'd10, 12'h004, 5'd6, 32'h0000_0400, 16'hFFFF, 0, 0);
    for (int r = 20; r < 28; r++) rf[r] = 64'(r * 5);
    run_op("R3 const stride vector", 0, 1, 5'd20, 5'd3, 2'd2, 5'd10, 12'h000, 5'd8, 32'h0010_0400, 16'hFFFF, 0, 0);
    run_op("R4 indexed", 1, 1, 5'd20, 5'd3, 2'd0, 5'd10, 12'hFFC, 5'd8, 32'h0010_0400, 16'hFFFF, 0, 0);
    run_op("R5 vector base wrap", 0, 0, 5'd7, 5'd29, 2'd3, 5'd30, 12'h001, 5'd6, 32'h6000_0000, 16'hFFFF, 0, 0);
    run_op("R6 sparse predicate", 1, 0, 5'd20, 5'd3, 2'd2, 5'd10, 12'h000, 5'd12, 32'h0010_0400, 16'b1010_0100_1001_0010, 0, 0);
    run_op("R7 scalar dest", 0, 0, 5'd7, 5'd3, 2'd3, 5'd11, 12'h020, 5'd10, 32'h0000_0000, 16'h0308, 0, 0);
    run_op("R8 scalar zeroing", 0, 0, 5'd7, 5'd3, 2'd3, 5'd11, 12'h020, 5'd10, 32'h0000_0000, 16'hFFFF, 1, 0);
    run_op("R8 vector zeroing", 0, 0, 5'd7, 5'd3, 2'd3, 5'd11, 12'h020, 5'd4, 32'h0000_0800, 16'hFFFF, 1, 0);
    run_op("R9 zero length", 0, 0, 5'd7, 5'd3, 2'd3, 5'd10, 12'h000, 5'd0, 32'h0000_0400, 16'hFFFF, 0, 0);
    run_op("R9 empty mask", 0, 0, 5'd7, 5'd3, 2'd3, 5'd10, 12'h000, 5'd9, 32'h0000_0400, 16'h0000, 0, 0);
    rf[4] = 64'hFFFF_FFFF_FFFF_FFF0; rf[5] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_op("R11 wrap", 0, 1, 5'd5, 5'd4, 2'd3, 5'd10, 12'h800, 5'd4, 32'h0000_0400, 16'hFFFF, 0, 0);
    run_op("R12 start while busy", 0, 0, 5'd7, 5'd3, 2'd2, 5'd10, 12'h008, 5'd10, 32'h0000_0400, 16'hFFFF, 0, 1);
    for (int w = 0; w < 4; w++)
      run_op("R1 size code", 0, 0, 5'd7, 5'd3, 2'(w), 5'd12, 12'h000, 5'd3, 32'h0000_1000, 16'hFFFF, 0, 0);

    for (int t = 0; t < 80; t++) begin
      for (int r = 0; r < 32; r++) rf[r] = {$urandom, $urandom};
      run_op("random R2 R3 R4 R5 R6", 1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
             2'($urandom), 5'($urandom), 12'($urandom), 5'($urandom % 17), $urandom,
             16'($urandom), ($urandom % 5) == 0, ($urandom % 4) == 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule